// File: doc/BRIEF.md
# Fracturable Multiply-Add-Accumulate Slice

This block is a three-stage pipelined arithmetic slice. Its eighteen-bit sub-multipliers can be regrouped at run time by a mode input. The slice can act as four independent 9x9 multipliers, three 12x12 multipliers, two 18x18 multipliers, or one 36x36 multiplier. It can also add two or four 18x18 products together, with an optional running accumulator. Each operand bus has its own signed/unsigned flag. A rounding step and a saturation step can each be enabled for every operation.

Slices chain in two directions. A 44-bit cascade output carries the accumulator to the next slice, and that slice's cascade input adds the value into its sum. An 18-bit tap path registers lane 0 of the X operand and presents it to the next slice, so a row of slices can form the delay line of an FIR filter. A clock enable freezes every register. A synchronous reset clears every register.

The mode codes are N9=0, N12=1, P18=2, W36=3, SOP2=4 and SOP4=5. Codes 6 and 7 are reserved.

Top module: `fmac_slice`

## Requirements
- R1: While `rst` is high at a clock edge, every register clears. After that edge, `res_out`, `out_vld`, `casc_out`, `ovf_flag` and `tap_out` all read 0.
- R2: An operation presented with `in_vld`=1 and `ce`=1 gives its result on `res_out`, with `out_vld`=1, after exactly three enabled clock edges. The latency is the same in every mode. `res_out` holds when no valid operation completes. Reserved mode codes 6 and 7 give a zero result.
- R3: Mode 0 (N9): `res_out[18i+17:18i]` holds the 18-bit product of `op_x[18i+8:18i]` and `op_y[18i+8:18i]`, for i = 0 to 3.
- R4: Mode 1 (N12): `res_out[24i+23:24i]` holds the 24-bit product of `op_x[24i+11:24i]` and `op_y[24i+11:24i]`, for i = 0 to 2.
- R5: Mode 2 (P18): `res_out[36i+35:36i]` holds the 36-bit product of `op_x[18i+17:18i]` and `op_y[18i+17:18i]`, for i = 0 and 1.
- R6: Mode 3 (W36): `res_out` holds the full 72-bit product of `op_x[35:0]` and `op_y[35:0]`. It is built from four 18x18 partial products, with the two cross terms weighted by 2^18 and the high term by 2^36.
- R7: `x_sgn` selects a two's-complement reading of every X operand field in every mode, and `y_sgn` does the same for Y. When a flag is low, its operand fields are read as unsigned.
- R8: Mode 4 (SOP2) adds the 18x18 products of lanes 0 and 1. Mode 5 (SOP4) adds the products of lanes 0 to 3. `casc_in`, read as signed, is added in at the final stage. `res_out` holds the 44-bit outcome sign-extended to 72 bits. `casc_out` shows the accumulator.
- R9: In the sum modes, `acc_en`=1 with `acc_clr`=0 adds the new sum to the accumulator. Any other combination loads the accumulator with the new sum. The non-sum modes leave the accumulator and `ovf_flag` unchanged.
- R10: When the sum does not fit in 44 signed bits, `ovf_flag` becomes 1. While accumulating, `ovf_flag` stays 1. A load sets it to that operation's own overflow. With `sat_en`=1, the accumulator clamps to 2^43-1 or -2^43. With `sat_en`=0, it wraps modulo 2^44.
- R11: With `rnd_en`=1 in the sum modes, `res_out` shows the accumulator value v rounded half-up to a multiple of 2^8: floor((v+128)/256)*256. The result is clamped if `sat_en`=1 and wrapped otherwise. The accumulator keeps the unrounded value.
- R12: On each enabled edge, `tap_out` loads `tap_in` when `tap_sel`=1, or `op_x[17:0]` otherwise. The same value replaces lane 0 of X for that operation.
- R13: While `ce`=0, no register changes, including the outputs and the accumulator.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| ce | input | 1 | Clock enable for all registers |
| in_vld | input | 1 | Operation present on the inputs |
| mode | input | 3 | Mode code (0 to 5) |
| op_x | input | 72 | X operand bus |
| op_y | input | 72 | Y operand bus |
| x_sgn | input | 1 | X fields are two's complement |
| y_sgn | input | 1 | Y fields are two's complement |
| acc_en | input | 1 | Add into the accumulator |
| acc_clr | input | 1 | Load the accumulator instead of adding |
| sat_en | input | 1 | Saturate instead of wrapping |
| rnd_en | input | 1 | Round the sum-mode output |
| tap_sel | input | 1 | Use tap_in as lane 0 of X |
| tap_in | input | 18 | Tap chain from the previous slice |
| casc_in | input | 44 | Cascade sum from the previous slice |
| res_out | output | 72 | Result fields or sign-extended sum |
| out_vld | output | 1 | res_out holds a new result |
| casc_out | output | 44 | Accumulator to the next slice |
| ovf_flag | output | 1 | Sticky accumulator overflow |
| tap_out | output | 18 | Registered lane-0 X operand |

## Verification
The bench targets the most negative operand in each lane under each combination of sign flags. A sign-extension error there would spill carries into the neighbouring result field, or into the upper half of the 36x36 product. Accumulation runs are pushed past the 44-bit limit, with and without saturation. A design that stops the overflow flag from being sticky, or that clamps when it should wrap, shows a wrong `casc_out` or a wrong `ovf_flag`. Clear pulses, clock-enable stalls and non-sum modes are mixed into the accumulation runs. A design that disturbs the accumulator or shifts the pipeline on a stall then shows a result that is off by one cycle or has a corrupted sum. Rounding is checked exactly at the half-way point and next to the positive limit.

// File: rtl/fmac_pkg.sv
`timescale 1ns/1ps
package fmac_pkg;
    localparam int LANE_W = 18;
    localparam int BUS_W  = 4 * LANE_W;
    localparam int SOP_W  = 2 * LANE_W + 4;

    typedef enum logic [2:0] {
        MD_N9   = 3'd0,
        MD_N12  = 3'd1,
        MD_P18  = 3'd2,
        MD_W36  = 3'd3,
        MD_SOP2 = 3'd4,
        MD_SOP4 = 3'd5,
        MD_RSV6 = 3'd6,
        MD_RSV7 = 3'd7
    } md_e;

    typedef struct packed {
        logic vld;
        md_e  md;
        logic acc_en;
        logic clr;
        logic sat;
        logic rnd;
    } ctl_t;

    function automatic logic is_sop(md_e m);
        return (m == MD_SOP2) || (m == MD_SOP4);
    endfunction
endpackage

// File: rtl/fmac_prod.sv
`timescale 1ns/1ps
module fmac_prod
    import fmac_pkg::*;
(
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce,
    input  ctl_t                    c_in,
    input  logic                    sx,
    input  logic                    sy,
    input  logic [BUS_W-1:0]        x,
    input  logic [BUS_W-1:0]        y,
    output ctl_t                    c_out,
    output logic [BUS_W-1:0]        word_q,
    output logic signed [SOP_W-1:0] sop_q
);
    localparam int HW = 2 * LANE_W;

    logic [17:0]              p9  [4];
    logic [23:0]              p12 [3];
    logic signed [HW+1:0]     p18 [4];
    logic [BUS_W-1:0]         word_d;
    logic signed [SOP_W-1:0]  sop_d;
    logic signed [BUS_W-1:0]  pll, plh, phl, phh, w36;
    logic signed [LANE_W:0]   xl, xh, yl, yh;

    for (genvar i = 0; i < 4; i++) begin : g_n9
        logic signed [9:0] xa, yb;
        assign xa    = {sx & x[18*i+8], x[18*i +: 9]};
        assign yb    = {sy & y[18*i+8], y[18*i +: 9]};
        assign p9[i] = 18'(xa) * 18'(yb);
    end

    for (genvar i = 0; i < 3; i++) begin : g_n12
        logic signed [12:0] xa, yb;
        assign xa     = {sx & x[24*i+11], x[24*i +: 12]};
        assign yb     = {sy & y[24*i+11], y[24*i +: 12]};
        assign p12[i] = 24'(xa) * 24'(yb);
    end

    for (genvar i = 0; i < 4; i++) begin : g_l18
        logic signed [LANE_W:0] xa, yb;
        assign xa     = {sx & x[LANE_W*i+LANE_W-1], x[LANE_W*i +: LANE_W]};
        assign yb     = {sy & y[LANE_W*i+LANE_W-1], y[LANE_W*i +: LANE_W]};
        assign p18[i] = (HW+2)'(xa) * (HW+2)'(yb);
    end

    // 36x36 from four 18x18 partial products; the low halves are unsigned
    assign xl  = {1'b0, x[LANE_W-1:0]};
    assign yl  = {1'b0, y[LANE_W-1:0]};
    assign xh  = {sx & x[HW-1], x[HW-1:LANE_W]};
    assign yh  = {sy & y[HW-1], y[HW-1:LANE_W]};
    assign pll = BUS_W'(xl) * BUS_W'(yl);
    assign plh = BUS_W'(xl) * BUS_W'(yh);
    assign phl = BUS_W'(xh) * BUS_W'(yl);
    assign phh = BUS_W'(xh) * BUS_W'(yh);
    assign w36 = (phh <<< HW) + ((plh + phl) <<< LANE_W) + pll;

    always_comb begin
        word_d = '0;
        sop_d  = '0;
        unique case (c_in.md)
            MD_N9:   for (int i = 0; i < 4; i++) word_d[18*i +: 18] = p9[i];
            MD_N12:  for (int i = 0; i < 3; i++) word_d[24*i +: 24] = p12[i];
            MD_P18:  word_d = {p18[1][HW-1:0], p18[0][HW-1:0]};
            MD_W36:  word_d = w36;
            MD_SOP2: sop_d  = SOP_W'(p18[0]) + SOP_W'(p18[1]);
            MD_SOP4: sop_d  = SOP_W'(p18[0]) + SOP_W'(p18[1])
                            + SOP_W'(p18[2]) + SOP_W'(p18[3]);
            default: begin
                word_d = '0;
                sop_d  = '0;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            c_out  <= '0;
            word_q <= '0;
            sop_q  <= '0;
        end else if (ce) begin
            c_out  <= c_in;
            word_q <= word_d;
            sop_q  <= sop_d;
        end
    end
endmodule

// File: rtl/fmac_accum.sv
`timescale 1ns/1ps
module fmac_accum
    import fmac_pkg::*;
#(
    parameter int ACC_W    = 44,
    parameter int RND_BITS = 8
) (
    input  logic                    clk,
    input  logic                    rst,
    input  logic                    ce,
    input  ctl_t                    c,
    input  logic [BUS_W-1:0]        word,
    input  logic signed [SOP_W-1:0] sop,
    input  logic [ACC_W-1:0]        casc_in,
    output logic [BUS_W-1:0]        res_q,
    output logic                    vld_q,
    output logic [ACC_W-1:0]        acc_q,
    output logic                    ovf_q
);
    localparam int TW = ACC_W + 3;
    localparam int RW = ACC_W + 2;
    localparam logic [ACC_W-1:0] MAXV = {1'b0, {(ACC_W-1){1'b1}}};
    localparam logic [ACC_W-1:0] MINV = {1'b1, {(ACC_W-1){1'b0}}};
    localparam logic signed [RW-1:0] HALF = RW'(1) <<< (RND_BITS - 1);

    logic                 sum_mode, keep, fits, rfit, ovf_d;
    logic signed [TW-1:0] total;
    logic signed [RW-1:0] rw, rv;
    logic [ACC_W-1:0]     acc_d, rnd_o, out_v;
    logic [BUS_W-1:0]     res_d;

    assign sum_mode = is_sop(c.md);
    assign keep     = c.acc_en && !c.clr;

    always_comb begin
        total = TW'(sop) + TW'($signed(casc_in))
              + (keep ? TW'($signed(acc_q)) : TW'(0));
        fits  = (total[TW-1:ACC_W-1] == '0) || (total[TW-1:ACC_W-1] == '1);
        if (fits || !c.sat) acc_d = total[ACC_W-1:0];
        else                acc_d = total[TW-1] ? MINV : MAXV;
        ovf_d = !fits || (keep && ovf_q);

        rw   = RW'($signed(acc_d)) + HALF;
        rv   = (rw >>> RND_BITS) <<< RND_BITS;
        rfit = (rv[RW-1:ACC_W-1] == '0) || (rv[RW-1:ACC_W-1] == '1);
        if (rfit || !c.sat) rnd_o = rv[ACC_W-1:0];
        else                rnd_o = rv[RW-1] ? MINV : MAXV;
        out_v = c.rnd ? rnd_o : acc_d;

        unique case (c.md)
            MD_N9, MD_N12, MD_P18, MD_W36: res_d = word;
            MD_SOP2, MD_SOP4:              res_d = BUS_W'($signed(out_v));
            default:                       res_d = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            res_q <= '0;
            vld_q <= 1'b0;
            acc_q <= '0;
            ovf_q <= 1'b0;
        end else if (ce) begin
            vld_q <= c.vld;
            if (c.vld) res_q <= res_d;
            if (c.vld && sum_mode) begin
                acc_q <= acc_d;
                ovf_q <= ovf_d;
            end
        end
    end

    a_r10_sticky_ovf: assert property (@(posedge clk) disable iff (rst)
        (ce && c.vld && sum_mode && keep && ovf_q) |=> ovf_q);
    a_r9_no_acc_touch: assert property (@(posedge clk) disable iff (rst)
        (ce && c.vld && !sum_mode) |=> ($stable(acc_q) && $stable(ovf_q)));
    a_r13_freeze: assert property (@(posedge clk) disable iff (rst)
        !ce |=> ($stable(acc_q) && $stable(res_q) && $stable(vld_q) && $stable(ovf_q)));
endmodule

// File: rtl/fmac_slice.sv
`timescale 1ns/1ps
module fmac_slice
    import fmac_pkg::*;
#(
    parameter int ACC_W    = 44,
    parameter int RND_BITS = 8
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               ce,
    input  logic               in_vld,
    input  logic [2:0]         mode,
    input  logic [BUS_W-1:0]   op_x,
    input  logic [BUS_W-1:0]   op_y,
    input  logic               x_sgn,
    input  logic               y_sgn,
    input  logic               acc_en,
    input  logic               acc_clr,
    input  logic               sat_en,
    input  logic               rnd_en,
    input  logic               tap_sel,
    input  logic [LANE_W-1:0]  tap_in,
    input  logic [ACC_W-1:0]   casc_in,
    output logic [BUS_W-1:0]   res_out,
    output logic               out_vld,
    output logic [ACC_W-1:0]   casc_out,
    output logic               ovf_flag,
    output logic [LANE_W-1:0]  tap_out
);
    ctl_t                    c1_q, c2;
    logic                    sx_q, sy_q;
    logic [BUS_W-1:0]        x_q, y_q, word2;
    logic signed [SOP_W-1:0] sop2;

    // stage 1: input registers, lane 0 of X taken from the tap chain on request
    always_ff @(posedge clk) begin
        if (rst) begin
            c1_q <= '0;
            sx_q <= 1'b0;
            sy_q <= 1'b0;
            x_q  <= '0;
            y_q  <= '0;
        end else if (ce) begin
            c1_q <= '{vld: in_vld, md: md_e'(mode), acc_en: acc_en,
                      clr: acc_clr, sat: sat_en, rnd: rnd_en};
            sx_q <= x_sgn;
            sy_q <= y_sgn;
            x_q  <= {op_x[BUS_W-1:LANE_W], tap_sel ? tap_in : op_x[LANE_W-1:0]};
            y_q  <= op_y;
        end
    end

    assign tap_out = x_q[LANE_W-1:0];

    fmac_prod i_prod (
        .clk(clk), .rst(rst), .ce(ce), .c_in(c1_q), .sx(sx_q), .sy(sy_q),
        .x(x_q), .y(y_q), .c_out(c2), .word_q(word2), .sop_q(sop2)
    );

    fmac_accum #(.ACC_W(ACC_W), .RND_BITS(RND_BITS)) i_accum (
        .clk(clk), .rst(rst), .ce(ce), .c(c2), .word(word2), .sop(sop2),
        .casc_in(casc_in), .res_q(res_out), .vld_q(out_vld),
        .acc_q(casc_out), .ovf_q(ovf_flag)
    );

    a_r2_final_stage: assert property (@(posedge clk) disable iff (rst)
        (ce && c2.vld) |=> out_vld);
    a_r12_tap_reg: assert property (@(posedge clk) disable iff (rst)
        ce |=> (tap_out == $past(tap_sel ? tap_in : op_x[LANE_W-1:0])));
endmodule

// File: tb/test_fmac_slice.sv
`timescale 1ns/1ps
module test_fmac_slice;
    logic        clk = 1'b0;
    logic        rst, ce, in_vld, x_sgn, y_sgn, acc_en, acc_clr, sat_en, rnd_en, tap_sel;
    logic [2:0]  mode;
    logic [71:0] op_x, op_y;
    logic [17:0] tap_in;
    logic [43:0] casc_in;
    logic [71:0] res_out;
    logic        out_vld, ovf_flag;
    logic [43:0] casc_out;
    logic [17:0] tap_out;

    int total = 0, bad = 0, cycles = 0;
    bit started = 0;

    always #10 clk = ~clk;

    fmac_slice i_fmac_slice (
        .clk(clk), .rst(rst), .ce(ce), .in_vld(in_vld), .mode(mode),
        .op_x(op_x), .op_y(op_y), .x_sgn(x_sgn), .y_sgn(y_sgn),
        .acc_en(acc_en), .acc_clr(acc_clr), .sat_en(sat_en), .rnd_en(rnd_en),
        .tap_sel(tap_sel), .tap_in(tap_in), .casc_in(casc_in),
        .res_out(res_out), .out_vld(out_vld), .casc_out(casc_out),
        .ovf_flag(ovf_flag), .tap_out(tap_out)
    );

    typedef struct packed {
        logic vld; logic [2:0] md; logic [71:0] x, y;
        logic sx, sy, ae, clr, sat, rnd;
    } tr_t;

    tr_t m_s1, m_s2;
    logic [71:0] m_res;
    logic        m_vld, m_ovf;
    logic [43:0] m_acc;
    logic [17:0] m_tap;
    string       m_tag = "R1";

    localparam logic signed [79:0] LIM_HI = (80'sd1 <<< 43) - 1;
    localparam logic signed [79:0] LIM_LO = -(80'sd1 <<< 43);

    function automatic logic signed [79:0] ext(logic [35:0] v, int w, logic s);
        logic signed [79:0] r = 0;
        for (int k = 0; k < w; k++) r[k] = v[k];
        if (s && v[w-1]) r = r - (80'sd1 <<< w);
        return r;
    endfunction

    function automatic logic signed [79:0] mul(logic [35:0] a, logic [35:0] b, int w,
                                               logic sa, logic sb);
        return ext(a, w, sa) * ext(b, w, sb);
    endfunction

    function automatic logic signed [79:0] fit44(logic signed [79:0] v, logic sat);
        if (v > LIM_HI) return sat ? LIM_HI : ext(36'(0), 1, 0) + $signed({36'd0, v[43:0]}) - ((v[43]) ? (80'sd1 <<< 44) : 80'sd0);
        if (v < LIM_LO) return sat ? LIM_LO : $signed({36'd0, v[43:0]}) - ((v[43]) ? (80'sd1 <<< 44) : 80'sd0);
        return v;
    endfunction

    // final-stage reference, applied when a transaction reaches the output
    task automatic finish_tr(tr_t t, logic [43:0] cin);
        logic signed [79:0] p, sum, acc_v, rv;
        logic keep;
        string tg;
        m_vld = t.vld;
        if (!t.vld) return;
        tg = "R2";
        case (t.md)
            3'd0: begin
                for (int i = 0; i < 4; i++) begin
                    p = mul(36'(t.x[18*i +: 9]), 36'(t.y[18*i +: 9]), 9, t.sx, t.sy);
                    m_res[18*i +: 18] = p[17:0];
                end
                tg = "R3";
            end
            3'd1: begin
                for (int i = 0; i < 3; i++) begin
                    p = mul(36'(t.x[24*i +: 12]), 36'(t.y[24*i +: 12]), 12, t.sx, t.sy);
                    m_res[24*i +: 24] = p[23:0];
                end
                tg = "R4";
            end
            3'd2: begin
                for (int i = 0; i < 2; i++) begin
                    p = mul(36'(t.x[18*i +: 18]), 36'(t.y[18*i +: 18]), 18, t.sx, t.sy);
                    m_res[36*i +: 36] = p[35:0];
                end
                tg = "R5";
            end
            3'd3: begin
                p = mul(t.x[35:0], t.y[35:0], 36, t.sx, t.sy);
                m_res = p[71:0];
                tg = "R6";
            end
            3'd4, 3'd5: begin
                sum = 0;
                for (int i = 0; i < ((t.md == 3'd4) ? 2 : 4); i++)
                    sum = sum + mul(36'(t.x[18*i +: 18]), 36'(t.y[18*i +: 18]), 18, t.sx, t.sy);
                keep = t.ae && !t.clr;
                sum = sum + ext(36'(0), 1, 0) + $signed({{36{cin[43]}}, cin});
                if (keep) sum = sum + $signed({{36{m_acc[43]}}, m_acc});
                m_ovf = (sum > LIM_HI || sum < LIM_LO) || (keep && m_ovf);
                acc_v = fit44(sum, t.sat);
                m_acc = acc_v[43:0];
                if (t.rnd) begin
                    rv = ((acc_v + 80'sd128) >>> 8) <<< 8;
                    rv = fit44(rv, t.sat);
                end else rv = acc_v;
                m_res = {{28{rv[43]}}, rv[43:0]};
                tg = t.rnd ? "R11" : (t.sat ? "R10" : (keep ? "R9" : "R8"));
            end
            default: m_res = '0;
        endcase
        if (t.md <= 3'd3 && (t.sx || t.sy)) tg = "R7";
        m_tag = tg;
    endtask

    always @(posedge clk) begin
        if (rst) begin
            m_s1 = '0; m_s2 = '0; m_res = '0; m_vld = 0; m_acc = '0; m_ovf = 0; m_tap = '0;
        end else if (ce) begin
            finish_tr(m_s2, casc_in);
            m_s2 = m_s1;
            m_s1 = '{vld: in_vld, md: mode,
                     x: {op_x[71:18], tap_sel ? tap_in : op_x[17:0]}, y: op_y,
                     sx: x_sgn, sy: y_sgn, ae: acc_en, clr: acc_clr,
                     sat: sat_en, rnd: rnd_en};
            m_tap = tap_sel ? tap_in : op_x[17:0];
        end
        cycles++;
    end

    task automatic check(bit ok, string tag, logic [71:0] act, logic [71:0] exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s: actual=%h expected=%h at cycle %0d", tag, act, exp, cycles);
        end
    endtask

    always @(negedge clk) begin
        if (started && !rst) begin
            check(out_vld === m_vld, "R2", 72'(out_vld), 72'(m_vld));
            check(res_out === m_res, m_tag, res_out, m_res);
            check(casc_out === m_acc, "R9", 72'(casc_out), 72'(m_acc));
            check(ovf_flag === m_ovf, "R10", 72'(ovf_flag), 72'(m_ovf));
            check(tap_out === m_tap, "R12", 72'(tap_out), 72'(m_tap));
        end
    end

    task automatic put(logic [2:0] md, logic [71:0] x, logic [71:0] y, logic sx, logic sy,
                       logic ae, logic clr, logic sat, logic rnd);
        in_vld = 1; mode = md; op_x = x; op_y = y; x_sgn = sx; y_sgn = sy;
        acc_en = ae; acc_clr = clr; sat_en = sat; rnd_en = rnd;
        @(negedge clk);
    endtask

    task automatic idle(int n);
        in_vld = 0;
        repeat (n) @(negedge clk);
    endtask

    always @(posedge clk) begin
        if (cycles > 20000) begin
            bad++; total++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    logic [71:0] hold_res;
    logic [43:0] hold_acc;

    initial begin
        rst = 1; ce = 1; in_vld = 0; mode = 0; op_x = '0; op_y = '0; x_sgn = 0; y_sgn = 0;
        acc_en = 0; acc_clr = 0; sat_en = 0; rnd_en = 0; tap_sel = 0; tap_in = '0; casc_in = '0;
        repeat (3) @(negedge clk);
        // R1: reset state
        check(res_out === '0 && out_vld === 0 && casc_out === '0 && ovf_flag === 0 && tap_out === '0,
              "R1", res_out, '0);
        rst = 0; started = 1;

        // narrow modes, corner operands, all sign combinations
        for (int s = 0; s < 4; s++) begin
            put(3'd0, {4{18'h001FF}}, {18'h00100, 18'h001FF, 18'h00001, 18'h000FF}, s[0], s[1], 0, 0, 0, 0);
            put(3'd1, {3{24'h000800}}, {24'h000FFF, 24'h000800, 24'h000001}, s[0], s[1], 0, 0, 0, 0);
            put(3'd2, {18'h0, 18'h0, 18'h20000, 18'h3FFFF}, {18'h0, 18'h0, 18'h20000, 18'h20000}, s[0], s[1], 0, 0, 0, 0);
            put(3'd3, {36'h0, 36'h800000000}, {36'h0, 36'hFFFFFFFFF}, s[0], s[1], 0, 0, 0, 0);
            put(3'd3, {36'h0, 36'h123456789}, {36'h0, 36'h987654321}, s[0], s[1], 0, 0, 0, 0);
        end
        put(3'd6, '1, '1, 0, 0, 0, 0, 0, 0);
        idle(3);

        // R8/R9: sums with cascade, accumulate runs with clear pulses
        casc_in = 44'h000_0000_1000;
        put(3'd4, {36'h0, 18'h00003, 18'h00005}, {36'h0, 18'h00007, 18'h0000B}, 0, 0, 0, 0, 0, 0);
        casc_in = 44'hFFF_FFFF_FFF0;
        put(3'd5, {4{18'h20000}}, {4{18'h3FFFF}}, 1, 1, 1, 1, 0, 0);
        put(3'd5, {4{18'h20000}}, {4{18'h20000}}, 1, 1, 1, 0, 0, 0);
        put(3'd2, {4{18'h12345}}, {4{18'h0ABCD}}, 0, 0, 1, 0, 0, 0);
        put(3'd4, {4{18'h3FFFF}}, {4{18'h3FFFF}}, 0, 0, 1, 0, 0, 0);
        put(3'd4, {4{18'h00010}}, {4{18'h00010}}, 0, 0, 1, 1, 0, 0);
        idle(3);

        // R10: overflow with and without saturation, then sticky, then clear
        casc_in = 44'h7FF_FFFF_FFFF;
        put(3'd4, {4{18'h1FFFF}}, {4{18'h1FFFF}}, 0, 0, 0, 0, 1, 0);
        casc_in = 44'h0;
        put(3'd4, {4{18'h00001}}, {4{18'h00001}}, 0, 0, 1, 0, 1, 0);
        put(3'd4, {4{18'h3FFFF}}, {4{18'h00001}}, 1, 0, 1, 0, 1, 0);
        put(3'd4, {4{18'h00002}}, {4{18'h00002}}, 0, 0, 1, 1, 1, 0);
        casc_in = 44'h800_0000_0000;
        put(3'd5, {4{18'h20000}}, {4{18'h1FFFF}}, 1, 1, 0, 0, 0, 0);
        put(3'd5, {4{18'h20000}}, {4{18'h1FFFF}}, 1, 1, 0, 0, 1, 0);
        idle(3);

        // R11: rounding at half-way, just below, and next to the positive limit
        casc_in = 44'h000_0000_0080;
        put(3'd4, '0, '0, 0, 0, 0, 0, 0, 1);
        casc_in = 44'h000_0000_007F;
        put(3'd4, '0, '0, 0, 0, 0, 0, 0, 1);
        casc_in = 44'hFFF_FFFF_FF80;
        put(3'd4, '0, '0, 0, 0, 0, 0, 0, 1);
        casc_in = 44'h7FF_FFFF_FFC0;
        put(3'd4, '0, '0, 0, 0, 0, 0, 1, 1);
        put(3'd4, '0, '0, 0, 0, 0, 0, 0, 1);
        casc_in = '0;
        idle(3);

        // R12: tap chain replaces lane 0 of X
        tap_sel = 1; tap_in = 18'h2ABCD;
        put(3'd2, {4{18'h00003}}, {4{18'h00002}}, 1, 0, 0, 0, 0, 0);
        tap_in = 18'h00007;
        put(3'd4, {4{18'h00003}}, {4{18'h00002}}, 0, 0, 0, 0, 0, 0);
        tap_sel = 0;
        idle(3);

        // R13: stall with operations in flight
        put(3'd5, {4{18'h00100}}, {4{18'h00100}}, 0, 0, 0, 1, 0, 0);
        put(3'd5, {4{18'h00200}}, {4{18'h00100}}, 0, 0, 1, 0, 0, 0);
        ce = 0;
        hold_res = res_out; hold_acc = casc_out;
        put(3'd4, '1, '1, 1, 1, 1, 1, 1, 1);
        put(3'd3, '1, '1, 1, 1, 1, 1, 1, 1);
        check(res_out === hold_res && casc_out === hold_acc, "R13", res_out, hold_res);
        ce = 1;
        put(3'd5, {4{18'h00001}}, {4{18'h00001}}, 0, 0, 1, 0, 0, 0);
        idle(4);

        // mixed random traffic
        for (int n = 0; n < 600; n++) begin
            ce = ($urandom % 8) != 0;
            tap_sel = ($urandom % 4) == 0;
            tap_in = 18'($urandom);
            casc_in = ($urandom % 2) ? 44'({$urandom, $urandom}) : 44'($signed(16'($urandom)));
            in_vld = ($urandom % 5) != 0;
            mode = 3'($urandom);
            op_x = 72'({$urandom, $urandom, $urandom});
            op_y = 72'({$urandom, $urandom, $urandom});
            x_sgn = 1'($urandom); y_sgn = 1'($urandom);
            acc_en = ($urandom % 4) != 0; acc_clr = ($urandom % 6) == 0;
            sat_en = 1'($urandom); rnd_en = ($urandom % 4) == 0;
            @(negedge clk);
        end
        ce = 1; tap_sel = 0;
        idle(4);

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule